// File: doc/BRIEF.md
# Jittered PWM Timing Generator

This block is the digital timing core of a fixed-frequency, current-mode switching controller. A system clock advances a period counter whose nominal length is fixed at build time for a 65 kHz or a 100 kHz switching rate. A slow triangular modulator continuously lengthens and shortens the period within ±7.5 % of nominal, completing one full sweep in a configurable time (6 ms by default). This spreads the switching energy across nearby frequencies.

Every period opens by setting a drive latch. The latch is cleared by one of two events. The first is a digitized current-sense trip, which is ignored during a short blanking window after turn-on. The second is the duty limit at 80 % of the period in progress. A skip request suppresses whole pulses, and a global enable forces the drive low at once. A ramp-phase output climbs with the counter over the first 80 % of each period, so an external compensation ramp can be synchronized to it. The comparators, the analog ramp current and the gate driver sit outside this block.

Top module: `pwmj_timing`

## Requirements
- R1: The nominal period is NOM = floor(CLK_KHZ / 65) clocks, or floor(CLK_KHZ / 100) clocks when SEL_FAST = 1. During reset, `drv_out` and `ramp_out` are 0, the period is NOM and the sweep offset is 0.
- R2: The period length is sampled only at the last clock of a period. The next period then lasts exactly NOM + offset clocks, where offset is the modulator value at that boundary. A period in progress is never shortened or extended.
- R3: The modulator offset moves by JIT_STEP every floor(floor(CLK_KHZ·SWEEP_US/1000) / (4·DEV))·JIT_STEP clocks, with DEV = floor(NOM·75/1000) (at least 1). It moves upward first and reverses after clamping at +DEV or −DEV. Every period therefore lies in [NOM−DEV, NOM+DEV].
- R4: Let cnt be the position within the period, with cnt = 0 on the first clock. If `drv_en` is high and `skip_req` is low while cnt = 0, `drv_out` is high from cnt = 1.
- R5: `drv_out` is high on at most LIM = floor(4·P/5) clocks of a period of length P. Without a trip, it falls when cnt reaches LIM + 1.
- R6: `cs_trip` is ignored while cnt ≤ BLANK, where BLANK = ceil(CLK_KHZ·BLANK_NS/10^6), at least 1. When `cs_trip` is seen high with BLANK < cnt < LIM, `drv_out` is low from the next clock until the next period begins. With the trip held high, each pulse lasts BLANK+1 clocks.
- R7: `skip_req` is sampled at cnt = 0. If it is high, no pulse is started in that period. Pulses resume in the first period that begins with `skip_req` low.
- R8: `ramp_out` equals cnt while cnt < LIM, holds LIM for the rest of the period, and returns to 0 at the period boundary.
- R9: While `drv_en` is low, `drv_out` is low in the same cycle. The latch stays cleared until a period begins with `drv_en` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| drv_en | input | 1 | Global drive enable; low forces the drive off |
| skip_req | input | 1 | Request to skip the pulse of the coming period |
| cs_trip | input | 1 | Digitized current-sense comparator trip |
| drv_out | output | 1 | Gate drive command |
| ramp_out | output | CW = clog2(NOM+DEV+1) | Ramp-phase position within the period |

## Verification
The bench builds the block with a 13 MHz-equivalent clock parameter and the 65 kHz option, which gives NOM = 200, DEV = 15 and BLANK = 3. It also shortens the sweep to 300 µs, so the modulator steps every 65 clocks. With these values, both clamp points of the triangular sweep are reached many times within a short run, and the blanking window is several clocks wide. The duty-limit edge, the held-trip pulse width of BLANK+1, and skip and enable changes at arbitrary positions in the period can therefore all be observed against a behavioural model on every clock.

// File: rtl/pwmj_pkg.sv
package pwmj_pkg;

    localparam int SLOW_KHZ   = 65;
    localparam int FAST_KHZ   = 100;
    localparam int JIT_PERMIL = 75;
    localparam int DUTY_NUM   = 4;
    localparam int DUTY_DEN   = 5;

    typedef enum logic {
        SWEEP_UP = 1'b0,
        SWEEP_DN = 1'b1
    } sweep_dir_e;

    // position flags of the period counter, consumed by the drive latch
    typedef struct packed {
        logic start;    // first clock of a period
        logic last;     // last clock of a period
        logic ramp_on;  // counter below the duty limit
        logic unblank;  // counter past the blanking window
    } phase_t;

    function automatic int div_ceil(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    function automatic int nominal_period(input int clk_khz, input bit fast);
        return clk_khz / (fast ? FAST_KHZ : SLOW_KHZ);
    endfunction

    function automatic int jitter_span(input int nom);
        int d;
        d = (nom * JIT_PERMIL) / 1000;
        return (d < 1) ? 1 : d;
    endfunction

    function automatic int at_least_one(input int v);
        return (v < 1) ? 1 : v;
    endfunction

endpackage

// File: rtl/pwmj_sweep.sv
module pwmj_sweep
    import pwmj_pkg::*;
#(
    parameter int DEV      = 115,
    parameter int STEP     = 1,
    parameter int STEP_CYC = 1304,
    parameter int OW       = 9
) (
    input  logic                 clk,
    input  logic                 rst,
    output logic signed [OW-1:0] off_o
);
    localparam int TW = $clog2(STEP_CYC + 1);
    localparam int SW = OW + 2;
    localparam logic signed [SW-1:0] HI = SW'(DEV);
    localparam logic signed [SW-1:0] LO = -HI;

    logic [TW-1:0]          tmr;
    sweep_dir_e             dir;
    logic signed [OW-1:0]   off;
    logic signed [SW-1:0]   up_sum, dn_sum;
    logic                   tick;

    assign tick   = (tmr == TW'(STEP_CYC - 1));
    assign up_sum = SW'(off) + SW'(STEP);
    assign dn_sum = SW'(off) - SW'(STEP);

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr <= '0;
            dir <= SWEEP_UP;
            off <= '0;
        end else if (tick) begin
            tmr <= '0;
            if (dir == SWEEP_UP) begin
                if (up_sum >= HI) begin
                    off <= OW'(HI);
                    dir <= SWEEP_DN;
                end else begin
                    off <= OW'(up_sum);
                end
            end else begin
                if (dn_sum <= LO) begin
                    off <= OW'(LO);
                    dir <= SWEEP_UP;
                end else begin
                    off <= OW'(dn_sum);
                end
            end
        end else begin
            tmr <= tmr + 1'b1;
        end
    end

    assign off_o = off;

    p_offset_span_r3: assert property (@(posedge clk) disable iff (rst)
        (SW'(off) <= HI) && (SW'(off) >= LO));

    p_offset_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !$past(tick) |-> $stable(off));

endmodule

// File: rtl/pwmj_period.sv
module pwmj_period
    import pwmj_pkg::*;
#(
    parameter int NOM       = 1538,
    parameter int PER_MIN   = 1423,
    parameter int PER_MAX   = 1653,
    parameter int BLANK_CYC = 19,
    parameter int CW        = 11,
    parameter int OW        = 9
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [OW-1:0] off_i,
    output logic [CW-1:0]        cnt_o,
    output logic [CW-1:0]        lim_o,
    output phase_t               ph_o
);
    localparam int PW = CW + 3;

    logic [CW-1:0] cnt, per, reload, lim;
    logic [PW-1:0] prod;
    phase_t        ph;

    assign reload = CW'(NOM + int'(off_i));
    assign prod   = PW'(per) * PW'(DUTY_NUM);
    assign lim    = CW'(prod / PW'(DUTY_DEN));

    assign ph.start   = (cnt == '0);
    assign ph.last    = (cnt == per - 1'b1);
    assign ph.ramp_on = (cnt < lim);
    assign ph.unblank = (cnt > CW'(BLANK_CYC));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            per <= CW'(NOM);
        end else if (ph.last) begin
            cnt <= '0;
            per <= reload;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign cnt_o = cnt;
    assign lim_o = lim;
    assign ph_o  = ph;

    p_period_span_r3: assert property (@(posedge clk) disable iff (rst)
        (per >= CW'(PER_MIN)) && (per <= CW'(PER_MAX)));

    p_reload_edge_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(ph.last) |-> $stable(per));

    p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        $past(ph.last) |-> (cnt == '0));

endmodule

// File: rtl/pwmj_gate.sv
module pwmj_gate
    import pwmj_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en_i,
    input  logic   skip_i,
    input  logic   trip_i,
    input  phase_t ph_i,
    output logic   drv_o
);
    logic drv_q, drv_d;

    always_comb begin
        drv_d = drv_q;
        if (!en_i)                           drv_d = 1'b0;
        else if (ph_i.start)                 drv_d = !skip_i;
        else if (!ph_i.ramp_on)              drv_d = 1'b0;
        else if (trip_i && ph_i.unblank)     drv_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) drv_q <= 1'b0;
        else     drv_q <= drv_d;
    end

    assign drv_o = drv_q;

    p_start_r4: assert property (@(posedge clk) disable iff (rst)
        $past(ph_i.start && en_i && !skip_i) |-> drv_q);

    p_duty_cap_r5: assert property (@(posedge clk) disable iff (rst)
        (!ph_i.ramp_on && !ph_i.start) |=> !drv_q);

    p_blanking_r6: assert property (@(posedge clk) disable iff (rst)
        $past(en_i && drv_q && ph_i.ramp_on && !ph_i.unblank && !ph_i.start) |-> drv_q);

    p_skip_r7: assert property (@(posedge clk) disable iff (rst)
        $past(ph_i.start && skip_i) |-> !drv_q);

    p_enable_r9: assert property (@(posedge clk) disable iff (rst)
        $past(!en_i) |-> !drv_q);

endmodule

// File: rtl/pwmj_timing.sv
module pwmj_timing
    import pwmj_pkg::*;
#(
    parameter int  CLK_KHZ  = 100000,
    parameter bit  SEL_FAST = 1'b0,
    parameter int  SWEEP_US = 6000,
    parameter int  BLANK_NS = 184,
    parameter int  JIT_STEP = 1,
    localparam int NOM      = nominal_period(CLK_KHZ, SEL_FAST),
    localparam int DEV      = jitter_span(NOM),
    localparam int CW       = $clog2(NOM + DEV + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          drv_en,
    input  logic          skip_req,
    input  logic          cs_trip,
    output logic          drv_out,
    output logic [CW-1:0] ramp_out
);
    localparam int OW        = $clog2(DEV + 1) + 1;
    localparam int SWEEP_CLK = (CLK_KHZ * SWEEP_US) / 1000;
    localparam int STEP_CYC  = at_least_one((SWEEP_CLK / (4 * DEV)) * JIT_STEP);
    localparam int BLANK_CYC = at_least_one(div_ceil(CLK_KHZ * BLANK_NS, 1000000));

    logic signed [OW-1:0] off;
    logic [CW-1:0]        cnt, lim;
    phase_t               ph;
    logic                 drv_q;

    pwmj_sweep #(
        .DEV(DEV), .STEP(JIT_STEP), .STEP_CYC(STEP_CYC), .OW(OW)
    ) u_sweep (
        .clk(clk), .rst(rst), .off_o(off)
    );

    pwmj_period #(
        .NOM(NOM), .PER_MIN(NOM - DEV), .PER_MAX(NOM + DEV),
        .BLANK_CYC(BLANK_CYC), .CW(CW), .OW(OW)
    ) u_period (
        .clk(clk), .rst(rst), .off_i(off),
        .cnt_o(cnt), .lim_o(lim), .ph_o(ph)
    );

    pwmj_gate u_gate (
        .clk(clk), .rst(rst), .en_i(drv_en), .skip_i(skip_req),
        .trip_i(cs_trip), .ph_i(ph), .drv_o(drv_q)
    );

    assign drv_out  = drv_q & drv_en;
    assign ramp_out = ph.ramp_on ? cnt : lim;

    p_ramp_zero_r8: assert property (@(posedge clk) disable iff (rst)
        $past(ph.last) |-> (ramp_out == '0));

endmodule

// File: tb/pwmj_timing_tb.sv
module pwmj_timing_tb;

    localparam int CLK_KHZ = 13000;
    localparam int SWP_US  = 300;
    localparam int NOM_E   = CLK_KHZ / 65;                       // 200
    localparam int DEV_E   = (NOM_E * 75) / 1000;                // 15
    localparam int BLANK_E = (CLK_KHZ * 184 + 999999) / 1000000; // 3
    localparam int STEP_E  = ((CLK_KHZ * SWP_US / 1000) / (4 * DEV_E)); // 65

    logic clk = 1'b0, rst = 1'b1, en = 1'b0, skip = 1'b0, cs = 1'b0;
    logic       drv;
    logic [7:0] ramp;

    always #5 clk = ~clk;

    pwmj_timing #(
        .CLK_KHZ(CLK_KHZ), .SEL_FAST(1'b0), .SWEEP_US(SWP_US),
        .BLANK_NS(184), .JIT_STEP(1)
    ) u_dut (
        .clk(clk), .rst(rst), .drv_en(en), .skip_req(skip),
        .cs_trip(cs), .drv_out(drv), .ramp_out(ramp)
    );

    int    n_cmp = 0, n_bad = 0;
    string tag = "R1";
    bit    done = 1'b0;

    task automatic chk(input string rq, input int act, input int exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", rq, what, act, exp, $time);
        end
    endtask

    // behavioural reference
    int m_cnt, m_per, m_off, m_tmr, o_lim;
    bit m_up, m_drv, n_drv;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_per = NOM_E; m_off = 0; m_tmr = 0; m_up = 1'b1; m_drv = 1'b0;
        end else begin
            o_lim = (m_per * 4) / 5;
            if (!en)                          n_drv = 1'b0;
            else if (m_cnt == 0)              n_drv = !skip;
            else if (m_cnt >= o_lim)          n_drv = 1'b0;
            else if (cs && m_cnt > BLANK_E)   n_drv = 1'b0;
            else                              n_drv = m_drv;
            if (m_cnt == m_per - 1) begin
                m_cnt = 0;
                m_per = NOM_E + m_off;
            end else begin
                m_cnt++;
            end
            if (m_tmr == STEP_E - 1) begin
                m_tmr = 0;
                if (m_up) begin
                    if (m_off + 1 >= DEV_E) begin m_off = DEV_E; m_up = 1'b0; end
                    else m_off++;
                end else begin
                    if (m_off - 1 <= -DEV_E) begin m_off = -DEV_E; m_up = 1'b1; end
                    else m_off--;
                end
            end else begin
                m_tmr++;
            end
            m_drv = n_drv;
        end
    end

    // per-clock comparison and per-period monitor
    int len = 0, on_cnt = 0, peak = 0, min_len = 100000, max_len = 0, last_on = 0;
    bit seen = 1'b0;
    int exp_ramp, lim_now;

    always @(negedge clk) begin
        if (!rst && !done) begin
            lim_now  = (m_per * 4) / 5;
            exp_ramp = (m_cnt < lim_now) ? m_cnt : lim_now;
            chk(tag, int'(drv), int'(m_drv && en), "drive");
            chk("R8", int'(ramp), exp_ramp, "ramp");
            if (ramp == 8'd0) begin
                if (seen) begin
                    n_cmp++;
                    if (len < NOM_E - DEV_E || len > NOM_E + DEV_E) begin
                        n_bad++;
                        $display("FAIL R3 period: actual %0d expected %0d..%0d", len, NOM_E - DEV_E, NOM_E + DEV_E);
                    end
                    n_cmp++;
                    if (on_cnt > (len * 4) / 5) begin
                        n_bad++;
                        $display("FAIL R5 on-time: actual %0d expected <= %0d", on_cnt, (len * 4) / 5);
                    end
                    chk("R8", peak, (len * 4) / 5, "ramp peak");
                    if (len < min_len) min_len = len;
                    if (len > max_len) max_len = len;
                    last_on = on_cnt;
                end
                seen = 1'b1; len = 1; on_cnt = int'(drv); peak = 0;
            end else begin
                len++;
                on_cnt += int'(drv);
                if (int'(ramp) > peak) peak = int'(ramp);
            end
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #2;
    endtask

    initial begin : watchdog
        for (int i = 0; i < 150000; i++) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] lf;
        int highs;
        // R1 reset state
        cycles(3);
        chk("R1", int'(drv), 0, "drive in reset");
        chk("R1", int'(ramp), 0, "ramp in reset");
        en = 1'b1; rst = 1'b0;
        @(negedge clk);
        chk("R4", int'(drv), 1, "drive after first start");
        chk("R8", int'(ramp), 1, "ramp after first start");
        #2;
        // R5 / R3 free running over a full sweep
        tag = "R5";
        cycles(4200);
        chk("R3", int'(max_len > NOM_E), 1, "longest period above nominal");
        chk("R3", int'(min_len < NOM_E), 1, "shortest period below nominal");
        chk("R5", int'(last_on > BLANK_E + 1), 1, "untripped pulse long");
        // R6 held trip
        tag = "R6";
        cs = 1'b1;
        cycles(1000);
        chk("R6", last_on, BLANK_E + 1, "held-trip pulse width");
        // R6 scattered trips
        lf = 16'hACE1;
        for (int i = 0; i < 2000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            cs = lf[0] & lf[3] & lf[7];
            cycles(1);
        end
        cs = 1'b0;
        // R7 skip: set while drive is off mid-period
        tag = "R7";
        while (!(drv == 1'b0 && ramp > 8'd20)) cycles(1);
        skip = 1'b1;
        highs = 0;
        for (int i = 0; i < 700; i++) begin
            cycles(1);
            highs += int'(drv);
        end
        chk("R7", highs, 0, "pulses while skipping");
        skip = 1'b0;
        highs = 0;
        for (int i = 0; i < 500; i++) begin
            cycles(1);
            highs += int'(drv);
        end
        chk("R7", int'(highs > 0), 1, "pulses resume");
        // R9 enable drop mid-pulse
        tag = "R9";
        while (ramp != 8'd10) cycles(1);
        chk("R9", int'(drv), 1, "drive high before drop");
        en = 1'b0;
        #1;
        chk("R9", int'(drv), 0, "drive low same cycle");
        cycles(20);
        en = 1'b1;
        highs = 0;
        while (ramp != 8'd0) begin
            cycles(1);
            if (ramp != 8'd0) highs += int'(drv);
        end
        chk("R9", highs, 0, "latch held until next period");
        cycles(3);
        chk("R4", int'(drv), 1, "drive back after re-enable");
        tag = "R2";
        cycles(1500);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule